// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Generator

This block produces the four gate signals for a phase-shifted full bridge. The left leg runs from a master time base and the right leg from a slave time base. Each time base counts up from zero and wraps, and each drives a square wave that is high for half of the period. Once per period the master issues a sync strobe. The cycle after that strobe, the slave counter is reloaded with a phase value. The phase value is the period multiplied by an unsigned fixed-point fraction. The reload shifts the right leg against the left leg, and that shift is what sets the power delivered by the bridge.

Each leg turns its square wave into an active-high complementary pair with a programmable dead time, so the two switches of a leg are never on together. The period, the phase fraction and the two dead times are sampled only at the master zero point, so a control loop can write them at any time. The same strobe that syncs the slave is also issued as an ADC start pulse and an interrupt pulse. A fault input latches a shutdown that holds all four gates low. The shutdown clears only on an explicit clear, and switching then restarts at a period boundary.

Top module: `psfb_pwm_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, all seven outputs are 0.
- R2: The master counter runs 0, 1, …, P−1 and then returns to 0, where P is the captured period. The cycle in which the master counter is 0 is the master zero cycle.
- R3: Each leg's internal square wave w goes to 1 in the cycle after its counter is 0. It goes to 0 in the cycle after its counter equals floor(P/2). It holds its value otherwise.
- R4: In the cycle after sync_o is 1, the slave counter takes the phase value. At all other times the slave counter counts and wraps like the master. The master counter never takes the phase value.
- R5: phase_i is unsigned with FRAC_W fractional bits and FINT_W integer bits. The phase value is floor(P·F / 2^FRAC_W), clamped to at most P−1.
- R6: For a leg with dead time d: the A output is 1 in cycle t+1 exactly when w was 1 in every cycle from t−d to t and the gates were enabled in cycle t. The B output is 1 in cycle t+1 exactly when w was 0 in every cycle from t−d to t and the gates were enabled in cycle t. A and B are never both 1.
- R7: db_left_i sets the dead time of the left (master) leg. db_right_i sets the dead time of the right (slave) leg.
- R8: prd_i, phase_i, db_left_i and db_right_i are sampled only in the master zero cycle. They take effect from the next cycle onward. Changes at any other time have no effect until the next master zero cycle.
- R9: If trip_i is 1 in a cycle, all four gate outputs are 0 in the next cycle. A trip latch is also set, and it keeps the gates disabled after trip_i falls.
- R10: A trip_clr_i pulse clears the latch only if trip_i is 0 in that same cycle. After the clear, the gates are enabled again from the cycle after the next master zero cycle.
- R11: sync_o, adc_soc_o and irq_o are identical. Each is 1 for exactly one cycle, in the cycle after each master zero cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prd_i | input | CNT_W | Period in clock cycles. Must be 4 or more. |
| phase_i | input | FINT_W+FRAC_W | Unsigned fixed-point phase fraction of the period |
| db_left_i | input | DB_W | Dead time of the left (master) leg, in cycles |
| db_right_i | input | DB_W | Dead time of the right (slave) leg, in cycles |
| trip_i | input | 1 | Fault input, active high |
| trip_clr_i | input | 1 | Trip latch clear strobe |
| left_a_o | output | 1 | Left leg high-side gate |
| left_b_o | output | 1 | Left leg low-side gate |
| right_a_o | output | 1 | Right leg high-side gate |
| right_b_o | output | 1 | Right leg low-side gate |
| sync_o | output | 1 | Master period sync strobe |
| adc_soc_o | output | 1 | ADC start-of-conversion strobe |
| irq_o | output | 1 | Interrupt strobe |

## Verification
The bench builds the block with CNT_W=10, DB_W=4, FINT_W=2 and FRAC_W=24. Short periods of 4 to 20 cycles then let every period in that range run for several full cycles. Each period is paired with phase fractions from 0 up past 1.0, which reaches both the clamp and the wrap-point cases. The 4-bit dead time reaches delays equal to or longer than half the period, where one gate of a pair never turns on at all. The two-bit integer field makes a phase command of 2.5 legal, so clamping can be observed at the ports.

// File: rtl/psfb_pkg.sv
package psfb_pkg;

  // Selects whether a time base accepts a phase reload.
  typedef enum logic {
    TB_MASTER = 1'b0,
    TB_SLAVE  = 1'b1
  } tb_role_e;

  // Number of bridge legs handled by the generator.
  localparam int NUM_LEGS = 2;

endpackage

// File: rtl/psfb_timebase.sv
module psfb_timebase #(
  parameter int                 CNT_W = 16,
  parameter psfb_pkg::tb_role_e ROLE  = psfb_pkg::TB_MASTER
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] prd,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero_o,
  output logic             wave_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic [CNT_W-1:0] half_cnt;
  logic             do_load;

  assign last_cnt = prd - 1'b1;
  assign half_cnt = prd >> 1;
  assign do_load  = (ROLE == psfb_pkg::TB_SLAVE) && load_en;
  assign zero_o   = (cnt_q == '0);

  // Up counter: a phase reload wins, otherwise wrap at the last count.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (do_load) begin
      cnt_q <= load_val;
    end else if (cnt_q >= last_cnt) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Square wave: set at zero, clear at half period.
  always_ff @(posedge clk) begin
    if (rst) begin
      wave_o <= 1'b0;
    end else if (cnt_q == '0) begin
      wave_o <= 1'b1;
    end else if (cnt_q == half_cnt) begin
      wave_o <= 1'b0;
    end
  end

  generate
    if (ROLE == psfb_pkg::TB_MASTER) begin : g_master_chk
      // R2: apart from the wrap to zero, the master only ever steps by one
      assert_master_step_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> (cnt_q == $past(cnt_q) + 1'b1));
    end else begin : g_slave_chk
      // R4: a reload request lands the phase value in the counter
      assert_slave_load_R4: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (cnt_q == $past(load_val)));
    end
  endgenerate

endmodule

// File: rtl/psfb_deadband.sv
module psfb_deadband #(
  parameter int DB_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wave,
  input  logic            en,
  input  logic [DB_W-1:0] dly,
  output logic            a_o,
  output logic            b_o
);

  localparam logic [DB_W-1:0] RUN_MAX = '1;

  logic            wave_last_q;
  logic [DB_W-1:0] run_q;
  logic [DB_W-1:0] run_nx;
  logic            settled;

  // run_nx counts how many earlier cycles the wave has held its present level.
  always_comb begin
    if (wave != wave_last_q) begin
      run_nx = '0;
    end else if (run_q == RUN_MAX) begin
      run_nx = run_q;
    end else begin
      run_nx = run_q + 1'b1;
    end
  end

  assign settled = (run_nx >= dly);

  always_ff @(posedge clk) begin
    if (rst) begin
      wave_last_q <= 1'b0;
      run_q       <= '0;
      a_o         <= 1'b0;
      b_o         <= 1'b0;
    end else begin
      wave_last_q <= wave;
      run_q       <= run_nx;
      a_o         <= en &  wave & settled;
      b_o         <= en & ~wave & settled;
    end
  end

  // R6: the complementary pair never conducts together
  assert_pair_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(a_o && b_o));

  // R6: a gate only turns on after the wave has been steady for the delay
  assert_rise_after_delay_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(a_o) |-> ($past(wave) && ($past(run_nx) >= $past(dly))));

endmodule

// File: rtl/psfb_trip_ctl.sv
module psfb_trip_ctl (
  input  logic clk,
  input  logic rst,
  input  logic trip_i,
  input  logic clr_i,
  input  logic zero_i,
  output logic en_o
);

  logic trip_q;
  logic arm_q;

  // Trip latch: the fault has priority over the clear strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      trip_q <= 1'b0;
    end else if (trip_i) begin
      trip_q <= 1'b1;
    end else if (clr_i) begin
      trip_q <= 1'b0;
    end
  end

  // Run permission is granted again only at a master zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q <= 1'b0;
    end else if (trip_i || trip_q) begin
      arm_q <= 1'b0;
    end else if (zero_i) begin
      arm_q <= 1'b1;
    end
  end

  assign en_o = arm_q & ~trip_q & ~trip_i;

  // R10: the latch is released only by a clear seen with the fault low
  assert_clear_guard_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(trip_q) |-> ($past(clr_i) && !$past(trip_i)));

  // R10: switching resumes only on a period boundary
  assert_rearm_at_zero_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(arm_q) |-> $past(zero_i));

endmodule

// File: rtl/psfb_pwm_gen.sv
module psfb_pwm_gen #(
  parameter int CNT_W  = 16,
  parameter int DB_W   = 8,
  parameter int FINT_W = 8,
  parameter int FRAC_W = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CNT_W-1:0]         prd_i,
  input  logic [FINT_W+FRAC_W-1:0] phase_i,
  input  logic [DB_W-1:0]          db_left_i,
  input  logic [DB_W-1:0]          db_right_i,
  input  logic                     trip_i,
  input  logic                     trip_clr_i,
  output logic                     left_a_o,
  output logic                     left_b_o,
  output logic                     right_a_o,
  output logic                     right_b_o,
  output logic                     sync_o,
  output logic                     adc_soc_o,
  output logic                     irq_o
);

  localparam int PH_W   = FINT_W + FRAC_W;
  localparam int PROD_W = CNT_W + PH_W;
  localparam int LEGS   = psfb_pkg::NUM_LEGS;

  // Values that are active for the present period
  logic [CNT_W-1:0] act_prd;
  logic [PH_W-1:0]  act_ph;
  logic [DB_W-1:0]  act_db [LEGS];

  logic [LEGS-1:0]  leg_zero;
  logic [LEGS-1:0]  leg_wave;
  logic [LEGS-1:0]  leg_a;
  logic [LEGS-1:0]  leg_b;
  logic             mst_zero;
  logic             gate_en;
  logic             sync_q;

  logic [PROD_W-1:0] phase_prod;
  logic [PROD_W-1:0] full_turn;
  logic              over_turn;
  logic [CNT_W-1:0]  phase_cnt;

  assign mst_zero = leg_zero[0];

  // Inputs are sampled only at the master zero point.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_prd   <= '1;
      act_ph    <= '0;
      act_db[0] <= '0;
      act_db[1] <= '0;
    end else if (mst_zero) begin
      act_prd   <= prd_i;
      act_ph    <= phase_i;
      act_db[0] <= db_left_i;
      act_db[1] <= db_right_i;
    end
  end

  // Phase count = integer part of period times fraction, held below the wrap.
  assign phase_prod = PROD_W'(act_prd) * PROD_W'(act_ph);
  assign full_turn  = PROD_W'(act_prd) << FRAC_W;
  assign over_turn  = (phase_prod >= full_turn);
  assign phase_cnt  = over_turn ? (act_prd - 1'b1) : CNT_W'(phase_prod >> FRAC_W);

  // Period strobes, one register each so every output is a flop.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q    <= 1'b0;
      adc_soc_o <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      sync_q    <= mst_zero;
      adc_soc_o <= mst_zero;
      irq_o     <= mst_zero;
    end
  end

  assign sync_o = sync_q;

  psfb_trip_ctl u_trip (
    .clk    (clk),
    .rst    (rst),
    .trip_i (trip_i),
    .clr_i  (trip_clr_i),
    .zero_i (mst_zero),
    .en_o   (gate_en)
  );

  // Leg 0 is the master (left), leg 1 the phase-loaded slave (right).
  generate
    for (genvar g = 0; g < LEGS; g++) begin : g_leg
      localparam psfb_pkg::tb_role_e LEG_ROLE =
        (g == 0) ? psfb_pkg::TB_MASTER : psfb_pkg::TB_SLAVE;

      psfb_timebase #(
        .CNT_W (CNT_W),
        .ROLE  (LEG_ROLE)
      ) u_tb (
        .clk      (clk),
        .rst      (rst),
        .prd      (act_prd),
        .load_en  (sync_q),
        .load_val (phase_cnt),
        .zero_o   (leg_zero[g]),
        .wave_o   (leg_wave[g])
      );

      psfb_deadband #(
        .DB_W (DB_W)
      ) u_db (
        .clk  (clk),
        .rst  (rst),
        .wave (leg_wave[g]),
        .en   (gate_en),
        .dly  (act_db[g]),
        .a_o  (leg_a[g]),
        .b_o  (leg_b[g])
      );
    end
  endgenerate

  assign left_a_o  = leg_a[0];
  assign left_b_o  = leg_b[0];
  assign right_a_o = leg_a[1];
  assign right_b_o = leg_b[1];

  // R5: the computed reload value never reaches the wrap point
  assert_phase_range_R5: assert property (@(posedge clk) disable iff (rst)
    (act_prd != '0) |-> (phase_cnt < act_prd));

  // R4: a zero phase command puts the slave at zero just after the sync
  assert_slave_zero_phase_R4: assert property (@(posedge clk) disable iff (rst)
    (sync_q && (phase_cnt == '0)) |=> leg_zero[1]);

  // R9: a fault seen in one cycle blanks every gate in the next
  assert_trip_blanks_R9: assert property (@(posedge clk) disable iff (rst)
    $past(trip_i) |-> !(left_a_o || left_b_o || right_a_o || right_b_o));

  // R11: the period strobe lasts a single cycle
  assert_strobe_single_R11: assert property (@(posedge clk) disable iff (rst)
    sync_o |=> !sync_o);

endmodule

// File: tb/psfb_pwm_gen_tb_top.sv
module psfb_pwm_gen_tb_top;

  localparam int CW = 10;
  localparam int DW = 4;
  localparam int IW = 2;
  localparam int FW = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [CW-1:0]    prd;
  logic [IW+FW-1:0] ph;
  logic [DW-1:0]    dbl, dbr;
  logic             trip, clr;
  logic la, lb, ra, rb, sync, soc, irq;

  psfb_pwm_gen #(
    .CNT_W (CW), .DB_W (DW), .FINT_W (IW), .FRAC_W (FW)
  ) dut_i (
    .clk (clk), .rst (rst), .prd_i (prd), .phase_i (ph),
    .db_left_i (dbl), .db_right_i (dbr), .trip_i (trip), .trip_clr_i (clr),
    .left_a_o (la), .left_b_o (lb), .right_a_o (ra), .right_b_o (rb),
    .sync_o (sync), .adc_soc_o (soc), .irq_o (irq)
  );

  int vec = 0;
  int bad = 0;
  bit done = 1'b0;

  // Behavioural model state, built from the requirements
  int     m_cnt, s_cnt, a_prd, a_dbl, a_dbr;
  longint a_frac;
  longint mh, sh;            // bit k = wave value k cycles ago
  int     m_w, s_w;
  int     e_la, e_lb, e_ra, e_rb, e_sync;
  int     trip_q, arm;

  task automatic model_reset();
    m_cnt = 0; s_cnt = 0; a_prd = (1 << CW) - 1; a_frac = 0;
    a_dbl = 0; a_dbr = 0; mh = 0; sh = 0; m_w = 0; s_w = 0;
    e_la = 0; e_lb = 0; e_ra = 0; e_rb = 0; e_sync = 0;
    trip_q = 0; arm = 0;
  endtask

  function automatic int held(longint h, int d, int lvl);
    longint m;
    m = (longint'(1) << (d + 1)) - 1;
    if (lvl != 0) return ((h & m) == m) ? 1 : 0;
    return ((h & m) == 0) ? 1 : 0;
  endfunction

  // Advance the model by one clock, using the inputs present now (R2..R11).
  task automatic model_step();
    int zero, en, phs, half, last, nm_cnt, ns_cnt, nm_w, ns_w;
    longint whole;
    zero  = (m_cnt == 0);
    en    = (arm != 0) && !trip && (trip_q == 0);
    whole = (longint'(a_prd) * a_frac) >> FW;
    phs   = (whole >= a_prd) ? a_prd - 1 : int'(whole);
    half  = a_prd / 2;
    last  = (a_prd - 1) & ((1 << CW) - 1);
    e_la  = en && held(mh, a_dbl, 1);
    e_lb  = en && held(mh, a_dbl, 0);
    e_ra  = en && held(sh, a_dbr, 1);
    e_rb  = en && held(sh, a_dbr, 0);
    nm_w  = (m_cnt == 0) ? 1 : (m_cnt == half) ? 0 : m_w;
    ns_w  = (s_cnt == 0) ? 1 : (s_cnt == half) ? 0 : s_w;
    nm_cnt = (m_cnt >= last) ? 0 : m_cnt + 1;
    if (e_sync != 0) ns_cnt = phs;
    else ns_cnt = (s_cnt >= last) ? 0 : s_cnt + 1;
    if (trip || trip_q != 0) arm = 0;
    else if (zero) arm = 1;
    if (trip) trip_q = 1;
    else if (clr) trip_q = 0;
    e_sync = zero;
    if (zero) begin
      a_prd = prd; a_frac = longint'(ph); a_dbl = dbl; a_dbr = dbr;
    end
    m_cnt = nm_cnt; s_cnt = ns_cnt; m_w = nm_w; s_w = ns_w;
    mh = (mh << 1) | longint'(nm_w);
    sh = (sh << 1) | longint'(ns_w);
  endtask

  task automatic check(string tag);
    logic [6:0] got, exp;
    got = {la, lb, ra, rb, sync, soc, irq};
    exp = {e_la[0], e_lb[0], e_ra[0], e_rb[0], e_sync[0], e_sync[0], e_sync[0]};
    vec++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s at vector %0d: got %b expected %b (la lb ra rb sync soc irq)",
               tag, vec, got, exp);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic wait_mcnt(int v, string tag);
    while (m_cnt != v) cyc(tag);
  endtask

  function automatic logic [IW+FW-1:0] frac_pick(int k);
    case (k)
      0:       return 26'h0000000;
      1:       return 26'h0400000;   // 0.25
      2:       return 26'h0800000;   // 0.5
      3:       return 26'h0FFFFFF;   // just below 1.0
      4:       return 26'h1000000;   // 1.0, clamped
      default: return 26'h2800000;   // 2.5, clamped
    endcase
  endfunction

  initial begin
    prd = 10'd20; ph = '0; dbl = '0; dbr = '0; trip = 1'b0; clr = 1'b0;
    model_reset();
    // R1: outputs held low during reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1 reset");
    end
    rst = 1'b0;
    cyc("R1 first cycle");

    // R2 R3 R11: plain 50% drive, no shift, no dead time
    run(80, "R2 R3 R11 baseline");

    // R4 R5: every period 4..20 against each phase fraction
    for (int n = 4; n <= 20; n++) begin
      for (int f = 0; f < 6; f++) begin
        prd = CW'(n);
        ph  = frac_pick(f);
        dbl = DW'((n + f) % 4);
        dbr = DW'((n + 2 * f) % 3);
        run(3 * n + 8, "R4 R5 R3 phase sweep");
      end
    end

    // R6 R7: dead-time pairs per leg, including delays past half period
    prd = 10'd14; ph = 26'h0666666;
    for (int l = 0; l < 8; l++) begin
      for (int r = 0; r < 8; r++) begin
        dbl = DW'(l); dbr = DW'(r);
        run(44, "R6 R7 dead band");
      end
    end

    // R8: changes away from the zero cycle wait for the next period
    prd = 10'd16; ph = 26'h0800000; dbl = 4'd2; dbr = 4'd1;
    run(40, "R8 setup");
    wait_mcnt(3, "R8");
    prd = 10'd9; ph = 26'h0C00000; dbl = 4'd3; dbr = 4'd0;
    run(5, "R8 mid-period change");
    wait_mcnt(0, "R8");
    run(30, "R8 new period");
    wait_mcnt(7, "R8");
    prd = 10'd11; ph = 26'h0200000; dbl = 4'd0; dbr = 4'd2;
    run(40, "R8 second change");

    // R9 R10: trip, ignored clear, latched hold, release
    prd = 10'd12; ph = 26'h04CCCCC; dbl = 4'd1; dbr = 4'd2;
    run(40, "R9 setup");
    wait_mcnt(7, "R9");
    trip = 1'b1;
    run(3, "R9 trip asserted");
    clr = 1'b1;
    cyc("R10 clear ignored while tripped");
    clr = 1'b0; trip = 1'b0;
    run(40, "R10 latch holds");
    wait_mcnt(5, "R10");
    clr = 1'b1;
    cyc("R10 clear");
    clr = 1'b0;
    run(40, "R10 resume at zero");
    wait_mcnt(2, "R9");
    trip = 1'b1;
    cyc("R9 second trip");
    trip = 1'b0;
    clr = 1'b1;
    cyc("R10 clear after trip low");
    clr = 1'b0;
    run(40, "R10 resume again");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

endmodule